// File: doc/BRIEF.md
# Ping-Pong Histogram Colour Stretch

This block watches an RGB pixel stream and builds, for every colour channel, an intensity histogram over a whole frame. Once the last pixel of the frame has arrived it walks each histogram from both ends to find a low and a high level per channel. While walking, it discards a programmable share of the darkest and of the brightest pixels. The levels found this way are used to apply a linear stretch to every channel of the following frame. The result is a simple white-balance and contrast correction whose parameters always lag the picture by one frame.

Two histogram banks alternate. One is filled by the incoming frame while the other, filled by the previous frame, is searched and then cleared during vertical blanking. Frame width and height are runtime inputs with compile-time upper limits. The search plus the clear must fit in the blanking gap. A sticky status bit records any start of frame that arrives too early.

Top module: `pingpong_awb`

## Requirements
- R1: While reset is asserted and after its release, before any pixel, `out_valid` and `stat_overrun` are low.
- R2: Every pixel of the first frame after reset leaves the block unchanged, because no statistics exist yet.
- R3: Each channel has its own histogram of 2^BIN_BITS bins. A component falls in the bin given by its BIN_BITS most significant bits, and its lower bits have no effect on the statistics.
- R4: The clip count is floor(cfg_width * cfg_height * cfg_clip_pct / 100). The low bin is the lowest bin at which the running count from bin 0 upward exceeds the clip count. The high bin is the highest bin at which the running count from the top bin downward exceeds it.
- R5: The low level is lowbin << (COMP_W - BIN_BITS) and the high level is highbin << (COMP_W - BIN_BITS). Each output component is floor((in - low) * FULL / (high - low)), with FULL = 2^COMP_W - 1. Inputs at or below the low level give 0, and results above FULL give FULL.
- R6: A channel whose high bin is not above its low bin passes its component through unchanged.
- R7: Statistics gathered on frame N apply to every pixel of frame N+1, starting with its start-of-frame pixel. Frame N+1 fills the other bank.
- R8: A frame starts at a valid pixel with `in_sof` set. It ends at the valid pixel with `in_eol` set on line number cfg_height. Width and height may change from frame to frame.
- R9: Each valid input pixel appears on the output exactly one clock later, with `out_sof` and `out_eol` copied from the input. `out_valid` is low one cycle after an idle input cycle.
- R10: The search and the clear take 2^BIN_BITS + 1 cycles after the last pixel of a frame. A start of frame that arrives while they are still running, i.e. after fewer than 2^BIN_BITS + 1 idle cycles, sets `stat_overrun`. The bit stays set until reset.
- R11: Pixels are packed with red in bits [3*COMP_W-1:2*COMP_W], green in the middle COMP_W bits and blue in bits [COMP_W-1:0], on both input and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_width | input | $clog2(MAX_W+1) | Active pixels per line |
| cfg_height | input | $clog2(MAX_H+1) | Lines per frame |
| cfg_clip_pct | input | 7 | Percentage discarded at each end, meaningful below 50 |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_pix | input | 3*COMP_W | Packed R, G, B input |
| out_valid | output | 1 | Output pixel strobe |
| out_sof | output | 1 | First output pixel of a frame |
| out_eol | output | 1 | Last output pixel of a line |
| out_pix | output | 3*COMP_W | Packed stretched R, G, B |
| stat_overrun | output | 1 | Sticky: a frame began before the search and clear finished |

## Verification
The bench builds the block with 8-bit components, 16 bins and a frame of at most 8 by 8 pixels. With these values a whole frame, its 17-cycle search and clear, and an exact per-pixel reference all fit in a few hundred cycles. Sixteen bins make it easy to build frames whose low bits vary while every pixel shares one bin, which reaches the degenerate pass-through case. Percentile clipping with a handful of outliers is visible at a 10 percent setting. A short blanking gap is enough to provoke an overrun.

// File: rtl/pph_pkg.sv
package pph_pkg;
  localparam int NCH = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SCAN  = 2'd1,
    PH_CLEAR = 2'd2
  } scan_ph_e;
endpackage

// File: rtl/pph_hist.sv
module pph_hist
  import pph_pkg::*;
#(
  parameter int BIN_BITS = 8,
  parameter int CNT_W    = 21
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc_en,
  input  logic                    inc_bank,
  input  logic [NCH*BIN_BITS-1:0] inc_key,
  input  logic                    clr_en,
  input  logic                    clr_bank,
  input  logic                    rd_bank,
  input  logic [BIN_BITS-1:0]     rd_lo_idx,
  input  logic [BIN_BITS-1:0]     rd_hi_idx,
  output logic [NCH*CNT_W-1:0]    rd_lo_cnt,
  output logic [NCH*CNT_W-1:0]    rd_hi_cnt
);
  localparam int NB = 1 << BIN_BITS;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [BIN_BITS-1:0] key;
    assign key = inc_key[c*BIN_BITS +: BIN_BITS];

    for (genvar b = 0; b < 2; b++) begin : g_bk
      logic [NB*CNT_W-1:0] row;
      for (genvar k = 0; k < NB; k++) begin : g_bin
        logic [CNT_W-1:0] cnt_q, cnt_d;
        always_comb begin
          cnt_d = cnt_q;
          if (clr_en && clr_bank == 1'(b))
            cnt_d = '0;
          else if (inc_en && inc_bank == 1'(b) && key == BIN_BITS'(k))
            cnt_d = cnt_q + 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) cnt_q <= '0;
          else        cnt_q <= cnt_d;
        end
        assign row[k*CNT_W +: CNT_W] = cnt_q;
      end
    end

    logic [NB*CNT_W-1:0] sel_row;
    assign sel_row = rd_bank ? g_bk[1].row : g_bk[0].row;
    assign rd_lo_cnt[c*CNT_W +: CNT_W] = sel_row[int'(rd_lo_idx)*CNT_W +: CNT_W];
    assign rd_hi_cnt[c*CNT_W +: CNT_W] = sel_row[int'(rd_hi_idx)*CNT_W +: CNT_W];
  end
endmodule

// File: rtl/pph_scan.sv
module pph_scan #(
  parameter int BIN_BITS = 8,
  parameter int CNT_W    = 21
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                step,
  input  logic [BIN_BITS-1:0] idx,
  input  logic [CNT_W-1:0]    clip,
  input  logic [CNT_W-1:0]    cnt_lo,
  input  logic [CNT_W-1:0]    cnt_hi,
  output logic [BIN_BITS-1:0] min_bin,
  output logic [BIN_BITS-1:0] max_bin
);
  logic [CNT_W-1:0]    cum_lo_q, cum_lo_d, cum_hi_q, cum_hi_d, sum_lo, sum_hi;
  logic                got_lo_q, got_lo_d, got_hi_q, got_hi_d;
  logic [BIN_BITS-1:0] min_q, min_d, max_q, max_d;

  always_comb begin
    cum_lo_d = cum_lo_q;
    cum_hi_d = cum_hi_q;
    got_lo_d = got_lo_q;
    got_hi_d = got_hi_q;
    min_d    = min_q;
    max_d    = max_q;
    sum_lo   = cum_lo_q + cnt_lo;
    sum_hi   = cum_hi_q + cnt_hi;
    if (start) begin
      cum_lo_d = '0;
      cum_hi_d = '0;
      got_lo_d = 1'b0;
      got_hi_d = 1'b0;
      min_d    = '0;
      max_d    = '1;
    end else if (step) begin
      cum_lo_d = sum_lo;
      cum_hi_d = sum_hi;
      if (!got_lo_q && sum_lo > clip) begin
        min_d    = idx;
        got_lo_d = 1'b1;
      end
      if (!got_hi_q && sum_hi > clip) begin
        max_d    = ~idx;
        got_hi_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cum_lo_q <= '0;
      cum_hi_q <= '0;
      got_lo_q <= 1'b0;
      got_hi_q <= 1'b0;
      min_q    <= '0;
      max_q    <= '0;
    end else begin
      cum_lo_q <= cum_lo_d;
      cum_hi_q <= cum_hi_d;
      got_lo_q <= got_lo_d;
      got_hi_q <= got_hi_d;
      min_q    <= min_d;
      max_q    <= max_d;
    end
  end

  assign min_bin = min_q;
  assign max_bin = max_q;
endmodule

// File: rtl/pph_stretch.sv
module pph_stretch #(
  parameter int COMP_W   = 10,
  parameter int BIN_BITS = 8
)(
  input  logic [COMP_W-1:0]   pix,
  input  logic                en,
  input  logic [BIN_BITS-1:0] min_bin,
  input  logic [BIN_BITS-1:0] max_bin,
  output logic [COMP_W-1:0]   res
);
  localparam int SH = COMP_W - BIN_BITS;
  localparam int PW = 2 * COMP_W;

  logic [COMP_W-1:0] lo, hi, span, above;
  logic [PW-1:0]     quo;

  always_comb begin
    lo    = COMP_W'(min_bin) << SH;
    hi    = COMP_W'(max_bin) << SH;
    span  = (hi > lo) ? hi - lo : COMP_W'(1);
    above = (pix > lo) ? pix - lo : '0;
    quo   = (PW'(above) * PW'({COMP_W{1'b1}})) / PW'(span);
    if (!en || max_bin <= min_bin)
      res = pix;
    else if (quo > PW'({COMP_W{1'b1}}))
      res = '1;
    else
      res = quo[COMP_W-1:0];
  end
endmodule

// File: rtl/pingpong_awb.sv
module pingpong_awb
  import pph_pkg::*;
#(
  parameter int COMP_W   = 10,
  parameter int BIN_BITS = 8,
  parameter int MAX_W    = 1920,
  parameter int MAX_H    = 1080
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(MAX_W+1)-1:0]   cfg_width,
  input  logic [$clog2(MAX_H+1)-1:0]   cfg_height,
  input  logic [6:0]                   cfg_clip_pct,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic                         in_eol,
  input  logic [3*COMP_W-1:0]          in_pix,
  output logic                         out_valid,
  output logic                         out_sof,
  output logic                         out_eol,
  output logic [3*COMP_W-1:0]          out_pix,
  output logic                         stat_overrun
);
  localparam int NB     = 1 << BIN_BITS;
  localparam int CNT_W  = $clog2(MAX_W*MAX_H + 1);
  localparam int W_W    = $clog2(MAX_W+1);
  localparam int H_W    = $clog2(MAX_H+1);
  localparam int PROD_W = W_W + H_W + 7;
  localparam int PIX_W  = NCH * COMP_W;
  localparam int KEY_W  = NCH * BIN_BITS;

  // reset: asserted at once, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  scan_ph_e          ph_q, ph_d;
  logic [BIN_BITS-1:0] idx_q, idx_d;
  logic [H_W-1:0]    line_q, line_d, line_base;
  logic              bank_q, bank_d, sbank_q, sbank_d;
  logic [CNT_W-1:0]  clip_q, clip_d;
  logic [KEY_W-1:0]  pend_min_q, pend_min_d, pend_max_q, pend_max_d;
  logic [KEY_W-1:0]  act_min_q, act_min_d, act_max_q, act_max_d;
  logic              pend_ok_q, pend_ok_d, act_ok_q, act_ok_d;
  logic              ovr_q, ovr_d;
  logic              ov_q, ov_d, osof_q, osof_d, oeol_q, oeol_d;
  logic [PIX_W-1:0]  opix_q, opix_d;

  logic              sof_now, frame_end, scan_start, scan_busy;
  logic [PROD_W-1:0] clip_prod;
  logic [KEY_W-1:0]  key, scan_min, scan_max, use_min, use_max;
  logic              use_ok;
  logic [NCH*CNT_W-1:0] cnt_lo, cnt_hi;
  logic [PIX_W-1:0]  str_pix;

  // frame tracking
  assign sof_now    = in_valid && in_sof;
  assign line_base  = sof_now ? '0 : line_q;
  assign frame_end  = in_valid && in_eol && (line_base == cfg_height - 1'b1);
  assign scan_busy  = (ph_q != PH_IDLE);
  assign scan_start = frame_end && !scan_busy;
  assign clip_prod  = PROD_W'(cfg_width) * PROD_W'(cfg_height) * PROD_W'(cfg_clip_pct);

  for (genvar c = 0; c < NCH; c++) begin : g_key
    assign key[c*BIN_BITS +: BIN_BITS] = in_pix[c*COMP_W + COMP_W - 1 -: BIN_BITS];
  end

  pph_hist #(.BIN_BITS(BIN_BITS), .CNT_W(CNT_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .inc_en    (in_valid),
    .inc_bank  (bank_q),
    .inc_key   (key),
    .clr_en    (ph_q == PH_CLEAR),
    .clr_bank  (sbank_q),
    .rd_bank   (sbank_q),
    .rd_lo_idx (idx_q),
    .rd_hi_idx (~idx_q),
    .rd_lo_cnt (cnt_lo),
    .rd_hi_cnt (cnt_hi)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pph_scan #(.BIN_BITS(BIN_BITS), .CNT_W(CNT_W)) u_scan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .start   (scan_start),
      .step    (ph_q == PH_SCAN),
      .idx     (idx_q),
      .clip    (clip_q),
      .cnt_lo  (cnt_lo[c*CNT_W +: CNT_W]),
      .cnt_hi  (cnt_hi[c*CNT_W +: CNT_W]),
      .min_bin (scan_min[c*BIN_BITS +: BIN_BITS]),
      .max_bin (scan_max[c*BIN_BITS +: BIN_BITS])
    );
    pph_stretch #(.COMP_W(COMP_W), .BIN_BITS(BIN_BITS)) u_stretch (
      .pix     (in_pix[c*COMP_W +: COMP_W]),
      .en      (use_ok),
      .min_bin (use_min[c*BIN_BITS +: BIN_BITS]),
      .max_bin (use_max[c*BIN_BITS +: BIN_BITS]),
      .res     (str_pix[c*COMP_W +: COMP_W])
    );
  end

  // a new frame picks up the freshest parameters at its first pixel
  assign use_ok  = sof_now ? pend_ok_q  : act_ok_q;
  assign use_min = sof_now ? pend_min_q : act_min_q;
  assign use_max = sof_now ? pend_max_q : act_max_q;

  always_comb begin
    ph_d       = ph_q;
    idx_d      = idx_q;
    bank_d     = bank_q;
    sbank_d    = sbank_q;
    clip_d     = clip_q;
    pend_min_d = pend_min_q;
    pend_max_d = pend_max_q;
    pend_ok_d  = pend_ok_q;
    act_min_d  = act_min_q;
    act_max_d  = act_max_q;
    act_ok_d   = act_ok_q;
    line_d     = line_base;
    if (frame_end)                line_d = '0;
    else if (in_valid && in_eol)  line_d = line_base + 1'b1;

    unique case (ph_q)
      PH_IDLE: if (frame_end) begin
        ph_d    = PH_SCAN;
        idx_d   = '0;
        sbank_d = bank_q;
        bank_d  = ~bank_q;
        clip_d  = CNT_W'(clip_prod / PROD_W'(100));
      end
      PH_SCAN: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == BIN_BITS'(NB-1)) ph_d = PH_CLEAR;
      end
      PH_CLEAR: begin
        ph_d       = PH_IDLE;
        pend_min_d = scan_min;
        pend_max_d = scan_max;
        pend_ok_d  = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase

    if (sof_now) begin
      act_min_d = pend_min_q;
      act_max_d = pend_max_q;
      act_ok_d  = pend_ok_q;
    end

    ovr_d  = ovr_q || (sof_now && scan_busy);
    ov_d   = in_valid;
    osof_d = sof_now;
    oeol_d = in_valid && in_eol;
    opix_d = in_valid ? str_pix : opix_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q       <= PH_IDLE;
      idx_q      <= '0;
      line_q     <= '0;
      bank_q     <= 1'b0;
      sbank_q    <= 1'b0;
      clip_q     <= '0;
      pend_min_q <= '0;
      pend_max_q <= '0;
      pend_ok_q  <= 1'b0;
      act_min_q  <= '0;
      act_max_q  <= '0;
      act_ok_q   <= 1'b0;
      ovr_q      <= 1'b0;
      ov_q       <= 1'b0;
      osof_q     <= 1'b0;
      oeol_q     <= 1'b0;
      opix_q     <= '0;
    end else begin
      ph_q       <= ph_d;
      idx_q      <= idx_d;
      line_q     <= line_d;
      bank_q     <= bank_d;
      sbank_q    <= sbank_d;
      clip_q     <= clip_d;
      pend_min_q <= pend_min_d;
      pend_max_q <= pend_max_d;
      pend_ok_q  <= pend_ok_d;
      act_min_q  <= act_min_d;
      act_max_q  <= act_max_d;
      act_ok_q   <= act_ok_d;
      ovr_q      <= ovr_d;
      ov_q       <= ov_d;
      osof_q     <= osof_d;
      oeol_q     <= oeol_d;
      opix_q     <= opix_d;
    end
  end

  assign out_valid    = ov_q;
  assign out_sof      = osof_q;
  assign out_eol      = oeol_q;
  assign out_pix      = opix_q;
  assign stat_overrun = ovr_q;
endmodule

// File: rtl/pph_checker.sv
module pph_checker #(
  parameter int PIX_W = 30
)(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eol,
  input logic [PIX_W-1:0] in_pix,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eol,
  input logic [PIX_W-1:0] out_pix,
  input logic             stat_overrun,
  input logic             busy,
  input logic             params_ok
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_MARKERS_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_sof == $past(in_sof) && out_eol == $past(in_eol))); // R9
  AST_NO_STATS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && !params_ok) |=> out_pix == $past(in_pix)); // R2
  AST_EARLY_SOF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && busy) |=> stat_overrun); // R10
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_overrun |=> stat_overrun); // R10
endmodule

bind pingpong_awb pph_checker #(.PIX_W(3*COMP_W)) u_pph_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .in_valid     (in_valid),
  .in_sof       (in_sof),
  .in_eol       (in_eol),
  .in_pix       (in_pix),
  .out_valid    (out_valid),
  .out_sof      (out_sof),
  .out_eol      (out_eol),
  .out_pix      (out_pix),
  .stat_overrun (stat_overrun),
  .busy         (scan_busy),
  .params_ok    (act_ok_q)
);

// File: tb/pingpong_awb_bench.sv
module pingpong_awb_bench;
  localparam int CW = 8, BB = 4, MW = 8, MH = 8;
  localparam int NB = 1 << BB, SH = CW - BB, FULL = (1 << CW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [3:0] cfg_width, cfg_height;
  logic [6:0] cfg_clip_pct;
  logic in_valid, in_sof, in_eol;
  logic [3*CW-1:0] in_pix;
  logic out_valid, out_sof, out_eol, stat_overrun;
  logic [3*CW-1:0] out_pix;

  pingpong_awb #(.COMP_W(CW), .BIN_BITS(BB), .MAX_W(MW), .MAX_H(MH)) u_pingpong_awb (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_clip_pct(cfg_clip_pct), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_pix(in_pix), .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_pix(out_pix), .stat_overrun(stat_overrun)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int frm [64];
  int mdl_ok = 0;
  int mdl_min [3];
  int mdl_max [3];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R5 R6 reference for one component; channel 2 is red (R11)
  function automatic int ref_comp(int c, int v);
    int lo, hi, q;
    if (mdl_ok == 0 || mdl_max[c] <= mdl_min[c]) return v;
    lo = mdl_min[c] << SH;
    hi = mdl_max[c] << SH;
    if (v <= lo) return 0;
    q = (v - lo) * FULL / (hi - lo);
    return (q > FULL) ? FULL : q;
  endfunction

  function automatic int ref_pix(int p);
    int r = 0;
    for (int c = 0; c < 3; c++) r |= ref_comp(c, (p >> (c*CW)) & FULL) << (c*CW);
    return r;
  endfunction

  // R3 R4 statistics of the frame just sent
  task automatic learn(int n, int pct);
    int clip, cum;
    int hist [NB];
    clip = n * pct / 100;
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < NB; k++) hist[k] = 0;
      for (int i = 0; i < n; i++) hist[((frm[i] >> (c*CW)) & FULL) >> SH]++;
      mdl_min[c] = 0; cum = 0;
      for (int k = 0; k < NB; k++) begin
        cum += hist[k];
        if (cum > clip) begin mdl_min[c] = k; break; end
      end
      mdl_max[c] = NB - 1; cum = 0;
      for (int k = NB - 1; k >= 0; k--) begin
        cum += hist[k];
        if (cum > clip) begin mdl_max[c] = k; break; end
      end
    end
    mdl_ok = 1;
  endtask

  task automatic check_out(int j, int w, string tag);
    int e = ref_pix(frm[j]);
    bit ok = out_valid && (int'(out_pix) == e) && (out_sof == (j == 0)) && (out_eol == ((j % w) == w - 1));
    check(ok, tag, int'(out_pix), e);
  endtask

  task automatic send_frame(int w, int h, int pct, int gap, bit chk, string tag);
    int n = w * h;
    cfg_width = 4'(w); cfg_height = 4'(h); cfg_clip_pct = 7'(pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (chk && i > 0) check_out(i - 1, w, tag);
      in_valid = 1'b1; in_sof = (i == 0); in_eol = ((i % w) == w - 1);
      in_pix = 24'(frm[i]);
    end
    @(negedge clk);
    if (chk) check_out(n - 1, w, tag);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    learn(n, pct);
    repeat (gap) @(negedge clk);
  endtask

  function automatic int pk(int r, int g, int b);
    return ((r & FULL) << (2*CW)) | ((g & FULL) << CW) | (b & FULL);
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 0; in_sof = 0; in_eol = 0; in_pix = '0;
    cfg_width = 4'd8; cfg_height = 4'd4; cfg_clip_pct = 7'd0;
    repeat (3) @(negedge clk);
    check(!out_valid && !stat_overrun, "R1 during reset", {out_valid, stat_overrun}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !stat_overrun, "R1 after release", {out_valid, stat_overrun}, 0);
  endtask

  task automatic t_first_frame;  // R2 first frame unchanged
    for (int i = 0; i < 32; i++) frm[i] = pk(i*7, 40 + i*5, 255 - i*6);
    send_frame(8, 4, 0, 20, 1, "R2 R9 first frame passthrough");
  endtask

  task automatic t_stretch;  // R5 R7 R8 R11 stretch with previous frame stats, new size
    for (int i = 0; i < 30; i++) frm[i] = pk(i*37, i*11 + 100, i*53 + 3);
    send_frame(6, 5, 0, 20, 1, "R5 R7 R8 R11 stretch from previous frame");
  endtask

  task automatic t_clip;  // R4 outliers removed by percentile
    for (int i = 0; i < 40; i++) frm[i] = pk(100 + (i % 20), 60 + i, 180 - i);
    frm[0] = pk(2, 60, 180);  frm[1] = pk(250, 61, 179);
    frm[2] = pk(100, 0, 178); frm[3] = pk(101, 255, 0);
    frm[4] = pk(102, 64, 255);
    send_frame(8, 5, 10, 20, 1, "R7 stretch after prior frame");
    for (int i = 0; i < 32; i++) frm[i] = pk(i*8, 255 - i*8, i*29);
    send_frame(8, 4, 0, 20, 1, "R4 R5 clipped levels and clamping");
  endtask

  task automatic t_degenerate;  // R3 R6 low bits ignored, one bin gives passthrough
    for (int i = 0; i < 16; i++) frm[i] = pk(8'h50 | (i % 16), 8'hA0 | ((i*3) % 16), 8'h30 | ((i*5) % 16));
    send_frame(4, 4, 0, 20, 1, "R5 stretch before one-bin frame");
    for (int i = 0; i < 64; i++) frm[i] = pk(i*37, i*11 + 100, i*53 + 3);
    send_frame(8, 8, 0, 20, 1, "R3 R6 single-bin stats pass through");
  endtask

  task automatic t_overrun;  // R10
    check(!stat_overrun, "R10 no overrun with long gap", int'(stat_overrun), 0);
    for (int i = 0; i < 8; i++) frm[i] = pk(i*30, 200 - i*20, 60 + i*9);
    send_frame(4, 2, 0, 0, 1, "R7 stretch before short gap");
    send_frame(4, 2, 0, 20, 0, "R10 early frame");
    check(stat_overrun, "R10 early start of frame flagged", int'(stat_overrun), 1);
    repeat (5) @(negedge clk);
    check(stat_overrun, "R10 overrun sticky", int'(stat_overrun), 1);
    check(!out_valid, "R9 idle output after frames", int'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_first_frame();
    t_stretch();
    t_clip();
    t_degenerate();
    t_overrun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule